// File: doc/BRIEF.md
# Dual Down-Counter Timer with Lockable Watchdog

This block holds two 32-bit down-counters that software sets up through a small register bus. Each counter has its own bank with a reload value, a readable live count, a control word and a sticky expiry flag. A control word holds a run enable, an auto-reload select, an interrupt enable and an 8-bit prescaler that slows the count rate. The first bank is a plain interval timer that raises a level interrupt. The second bank can work as a second timer, or it can be switched into a guard mode. In guard mode an expiry fires a one-cycle reset request instead of an interrupt, and it leaves a sticky reset flag behind.

Software can enter guard mode with one control write. It can only leave guard mode by writing two fixed key words to a dedicated disable register, back to back. A control write can never clear the mode. This means a runaway program cannot easily switch the guard off.

The register bus is a plain single-cycle write strobe with a combinational read port. It is a control path and not a data stream, so there is no valid/ready handshake. A write takes effect at the clock edge where `reg_wen` is sampled high. Read data follows `reg_addr` in the same cycle. Addresses are byte addresses. Any address whose two low bits are not zero, and any address that is not mapped, reads as zero and ignores writes.

Top module: `ltmr_top`

## Requirements
- R1: After reset every register reads 0 and all three outputs are low. A counter whose reload register has not been written since reset produces no expiry, even when it is enabled.
- R2: Register map, by byte address. Timer bank: 0x00 reload, 0x04 count, 0x08 control, 0x0C status. Guard bank: 0x20 reload, 0x24 count, 0x28 control, 0x2C status, 0x30 reset flag, 0x34 disable. A write to a reload register also puts the same value into the count register at that edge. Writes to a count register are ignored.
- R3: Control bit 0 is the run enable. Control bits 15:8 hold a prescaler value P. While running, the count drops by one every P+1 clocks. While stopped, the count holds its value.
- R4: With reload value N, an expiry occurs (N+1)*(P+1) clocks after the control write that starts the counter. The expiry happens on the prescaled step taken while the count is 0. It sets status bit 0.
- R5: When control bit 1 (auto-reload) is set, an expiry copies the reload value back into the count. The expiry then repeats every (N+1)*(P+1) clocks.
- R6: When auto-reload is clear, the count stays at 0 after an expiry, and no further expiry occurs until the reload register is written again.
- R7: Writing 1 to status bit 0 clears it. Writing 0 to it has no effect. An expiry in the same cycle as a clear leaves the bit set.
- R8: `tmr_irq` is high while timer status bit 0 and timer control bit 2 are both set. `wdt_irq` follows the same rule for the guard bank, but it is held low while the guard bank is in guard mode.
- R9: Control bit 3 of the guard bank selects guard mode. The same bit in the timer bank always reads 0. In guard mode an expiry drives `wdt_rst_req` high for exactly the one clock that follows the expiry edge, and it sets bit 0 of the reset flag register. Writing 1 to that bit clears it.
- R10: A control write cannot clear guard mode. Guard mode is cleared only by a write of 0x12345678 to the disable register, followed by a write of 0x87654321 as the very next write to that register. Any other value written in between breaks the sequence, which must then restart from the first word. The disable register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Write strobe, sampled at the clock edge |
| reg_addr | input | 6 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tmr_irq | output | 1 | Timer bank interrupt, level |
| wdt_irq | output | 1 | Guard bank interrupt, level, only outside guard mode |
| wdt_rst_req | output | 1 | One-clock reset request on a guard-mode expiry |

## Verification
Most internal faults in this block appear at the ports as a timing error. A wrong prescaler compare or a wrong expiry condition moves the edge where the status flag rises, and that edge lands a whole number of prescaled periods early or late. The bench therefore samples the status flag in the cycle just before the computed expiry edge and in the cycle just after it. A lost one-shot stop bit shows up within one more period as a second expiry that should not happen. A faulty unlock sequencer shows up at once: either the control readback of the guard bank still reports guard mode after a valid key pair, or the mode is lost after a broken key sequence. A mode bit that is stuck or clears too easily moves the reset pulse onto the interrupt pin, so the fault is visible in the expiry cycle itself.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;

  parameter int DATA_W = 32;
  parameter int PSC_W  = 8;
  parameter int ADDR_W = 6;

  // word index inside one bank (byte offset / 4)
  localparam logic [2:0] W_LOAD  = 3'd0;
  localparam logic [2:0] W_COUNT = 3'd1;
  localparam logic [2:0] W_CTRL  = 3'd2;
  localparam logic [2:0] W_STAT  = 3'd3;
  localparam logic [2:0] W_RFLAG = 3'd4;
  localparam logic [2:0] W_DIS   = 3'd5;

  localparam int N_BANKS = 2;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic             wdog;
    logic             irq_en;
    logic             auto_rld;
    logic             run;
  } ltmr_ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_pack(ltmr_ctrl_t c);
    logic [DATA_W-1:0] v;
    v            = '0;
    v[0]         = c.run;
    v[1]         = c.auto_rld;
    v[2]         = c.irq_en;
    v[3]         = c.wdog;
    v[8 +: PSC_W] = c.psc;
    return v;
  endfunction

endpackage

// File: rtl/ltmr_unlock.sv
module ltmr_unlock #(
  parameter int          KW    = 32,
  parameter logic [31:0] KEY_A = 32'h1234_5678,
  parameter logic [31:0] KEY_B = 32'h8765_4321
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_dis,
  input  logic [KW-1:0] wdata,
  output logic          exit_pulse
);

  logic armed;

  // every write to the disable register re-decides the armed state
  always_ff @(posedge clk) begin
    if (!rst_n)      armed <= 1'b0;
    else if (wr_dis) armed <= (wdata == KEY_A[KW-1:0]);
  end

  assign exit_pulse = wr_dis && armed && (wdata == KEY_B[KW-1:0]);

  // R10
  armed_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wr_dis && wdata == KEY_A[KW-1:0]));

  // R10
  armed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_dis && wdata != KEY_A[KW-1:0]) |=> !armed);

endmodule

// File: rtl/ltmr_bank.sv
module ltmr_bank
  import ltmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit WDOG_CAP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_load,
  input  logic             wr_ctrl,
  input  logic             wr_stat,
  input  logic             wr_rflag,
  input  logic [CNT_W-1:0] wdata,
  input  ltmr_ctrl_t       ctrl_wr,
  input  logic             mode_exit,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cnt_q,
  output ltmr_ctrl_t       ctrl_q,
  output logic             stat_q,
  output logic             rflag_q,
  output logic             irq,
  output logic             rst_pulse
);

  logic [PSC_W-1:0] psc_cnt;
  logic             tick;
  logic             done;
  logic             expire;

  assign tick   = ctrl_q.run && (psc_cnt == ctrl_q.psc);
  assign expire = tick && (cnt_q == '0) && !done;

  // prescaler: restarts on a reload write or while stopped
  always_ff @(posedge clk) begin
    if (!rst_n)                        psc_cnt <= '0;
    else if (!ctrl_q.run || wr_load)   psc_cnt <= '0;
    else if (tick)                     psc_cnt <= '0;
    else                               psc_cnt <= psc_cnt + PSC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       load_q <= '0;
    else if (wr_load) load_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_load) begin
      cnt_q <= wdata;
    end else if (tick) begin
      if (cnt_q != '0)                 cnt_q <= cnt_q - CNT_W'(1);
      else if (expire && ctrl_q.auto_rld) cnt_q <= load_q;
    end
  end

  // done marks a finished one-shot; reset starts as done so an unloaded
  // counter never fires
  always_ff @(posedge clk) begin
    if (!rst_n)                           done <= 1'b1;
    else if (wr_load)                     done <= 1'b0;
    else if (expire && !ctrl_q.auto_rld)  done <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      stat_q <= 1'b0;
    else if (expire)                 stat_q <= 1'b1;
    else if (wr_stat && wdata[0])    stat_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.run      <= ctrl_wr.run;
        ctrl_q.auto_rld <= ctrl_wr.auto_rld;
        ctrl_q.irq_en   <= ctrl_wr.irq_en;
        ctrl_q.psc      <= ctrl_wr.psc;
      end
      if (WDOG_CAP) begin
        if (mode_exit)                      ctrl_q.wdog <= 1'b0;
        else if (wr_ctrl && ctrl_wr.wdog)   ctrl_q.wdog <= 1'b1;
      end
    end
  end

  assign irq = stat_q && ctrl_q.irq_en && !ctrl_q.wdog;

  generate
    if (WDOG_CAP) begin : g_guard
      always_ff @(posedge clk) begin
        if (!rst_n)                        rflag_q <= 1'b0;
        else if (expire && ctrl_q.wdog)    rflag_q <= 1'b1;
        else if (wr_rflag && wdata[0])     rflag_q <= 1'b0;
      end

      always_ff @(posedge clk) begin
        if (!rst_n) rst_pulse <= 1'b0;
        else        rst_pulse <= expire && ctrl_q.wdog;
      end

      // R9
      pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> rflag_q);

      // R10
      mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.wdog && wr_ctrl && !mode_exit) |=> ctrl_q.wdog);
    end else begin : g_plain
      logic unused_guard;
      assign unused_guard = wr_rflag ^ mode_exit ^ ctrl_wr.wdog;
      assign rflag_q      = 1'b0;
      assign rst_pulse    = 1'b0;
    end
  endgenerate

  // R2
  cnt_le_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= load_q);

  // R6
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_load) |=> $stable(cnt_q));

  // R4
  stat_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(cnt_q == '0));

  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !wr_load) |=> $stable(cnt_q));

endmodule

// File: rtl/ltmr_top.sv
module ltmr_top
  import ltmr_pkg::*;
#(
  parameter int          CNT_W = 32,
  parameter logic [31:0] KEY_A = 32'h1234_5678,
  parameter logic [31:0] KEY_B = 32'h8765_4321
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tmr_irq,
  output logic              wdt_irq,
  output logic              wdt_rst_req
);

  localparam int BANK_BIT = ADDR_W - 1;
  localparam int GUARD    = N_BANKS - 1;

  logic       hit;
  logic       bsel;
  logic [2:0] word;
  logic       wr_dis;
  logic       exit_pulse;
  ltmr_ctrl_t ctrl_wr;

  logic [CNT_W-1:0] ld_a   [N_BANKS];
  logic [CNT_W-1:0] cnt_a  [N_BANKS];
  ltmr_ctrl_t       ctrl_a [N_BANKS];
  logic             stat_a [N_BANKS];
  logic             rflag_a[N_BANKS];
  logic             irq_a  [N_BANKS];
  logic             rstp_a [N_BANKS];

  assign hit  = (reg_addr[1:0] == 2'b00);
  assign bsel = reg_addr[BANK_BIT];
  assign word = reg_addr[4:2];

  assign ctrl_wr = '{psc:      reg_wdata[8 +: PSC_W],
                     wdog:     reg_wdata[3],
                     irq_en:   reg_wdata[2],
                     auto_rld: reg_wdata[1],
                     run:      reg_wdata[0]};

  assign wr_dis = reg_wen && hit && bsel && (word == W_DIS);

  ltmr_unlock #(
    .KW    (DATA_W),
    .KEY_A (KEY_A),
    .KEY_B (KEY_B)
  ) u_unlock (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_dis     (wr_dis),
    .wdata      (reg_wdata),
    .exit_pulse (exit_pulse)
  );

  generate
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = reg_wen && hit && (bsel == 1'(b));

      ltmr_bank #(
        .CNT_W    (CNT_W),
        .WDOG_CAP (b == GUARD)
      ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_load   (sel && word == W_LOAD),
        .wr_ctrl   (sel && word == W_CTRL),
        .wr_stat   (sel && word == W_STAT),
        .wr_rflag  (sel && word == W_RFLAG),
        .wdata     (reg_wdata[CNT_W-1:0]),
        .ctrl_wr   (ctrl_wr),
        .mode_exit ((b == GUARD) ? exit_pulse : 1'b0),
        .load_q    (ld_a[b]),
        .cnt_q     (cnt_a[b]),
        .ctrl_q    (ctrl_a[b]),
        .stat_q    (stat_a[b]),
        .rflag_q   (rflag_a[b]),
        .irq       (irq_a[b]),
        .rst_pulse (rstp_a[b])
      );
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      case (word)
        W_LOAD:  reg_rdata[CNT_W-1:0] = ld_a[bsel];
        W_COUNT: reg_rdata[CNT_W-1:0] = cnt_a[bsel];
        W_CTRL:  reg_rdata            = ctrl_pack(ctrl_a[bsel]);
        W_STAT:  reg_rdata[0]         = stat_a[bsel];
        W_RFLAG: reg_rdata[0]         = rflag_a[bsel];
        default: reg_rdata            = '0;
      endcase
    end
  end

  assign tmr_irq     = irq_a[0];
  assign wdt_irq     = irq_a[GUARD];
  assign wdt_rst_req = rstp_a[0] | rstp_a[GUARD];

  // R10
  mode_exit_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_a[GUARD].wdog) |-> $past(wr_dis && reg_wdata == KEY_B[DATA_W-1:0]));

  // R9
  timer_no_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_a[0].wdog && !rstp_a[0]);

  // R8
  guard_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> !wdt_irq);

endmodule

// File: tb/ltmr_top_bench.sv
`timescale 1ns/100ps
module ltmr_top_bench;

  localparam logic [31:0] KA = 32'h1234_5678;
  localparam logic [31:0] KB = 32'h8765_4321;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tmr_irq, wdt_irq, wdt_rst_req;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ltmr_top u_ltmr_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wen     (reg_wen),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .tmr_irq     (tmr_irq),
    .wdt_irq     (wdt_irq),
    .wdt_rst_req (wdt_rst_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // write lands on the posedge between the two negedges
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.2;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    foreach (v[i]) ; // no-op keeps loop var local style
    for (int a = 0; a < 64; a += 4) begin
      rd(6'(a), v);
      check("R1 reset read", v, 32'h0);
    end
    check("R1 tmr_irq", {31'b0, tmr_irq}, 32'h0);
    check("R1 wdt_irq", {31'b0, wdt_irq}, 32'h0);
    check("R1 rst_req", {31'b0, wdt_rst_req}, 32'h0);
    wr(6'h08, 32'h7);
    repeat (10) @(negedge clk);
    rd(6'h0C, v);
    check("R1 no event unloaded", v, 32'h0);
    wr(6'h08, 32'h0);
  endtask

  task automatic t_load_hold;
    logic [31:0] v;
    wr(6'h00, 32'd10);
    rd(6'h04, v);
    check("R2 load copies to count", v, 32'd10);
    wr(6'h04, 32'd7);
    rd(6'h04, v);
    check("R2 count write ignored", v, 32'd10);
    repeat (5) @(negedge clk);
    rd(6'h04, v);
    check("R3 stopped holds", v, 32'd10);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(6'h00, 32'd4);
    wr(6'h08, 32'h5);
    repeat (4) @(negedge clk);
    rd(6'h0C, v);
    check("R4 before expiry", v, 32'h0);
    @(negedge clk);
    rd(6'h0C, v);
    check("R4 at expiry", v, 32'h1);
    check("R8 tmr_irq", {31'b0, tmr_irq}, 32'h1);
    repeat (10) @(negedge clk);
    rd(6'h04, v);
    check("R6 count stays zero", v, 32'h0);
    wr(6'h0C, 32'h0);
    rd(6'h0C, v);
    check("R7 write 0 no effect", v, 32'h1);
    wr(6'h0C, 32'h1);
    rd(6'h0C, v);
    check("R7 w1c clears", v, 32'h0);
    check("R8 tmr_irq low", {31'b0, tmr_irq}, 32'h0);
    repeat (20) @(negedge clk);
    rd(6'h0C, v);
    check("R6 single event", v, 32'h0);
    wr(6'h08, 32'h0);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    wr(6'h00, 32'd3);
    wr(6'h08, 32'h207);
    repeat (11) @(negedge clk);
    rd(6'h0C, v);
    check("R3 prescaled before expiry", v, 32'h0);
    @(negedge clk);
    rd(6'h0C, v);
    check("R4 prescaled expiry", v, 32'h1);
    rd(6'h04, v);
    check("R5 reloaded", v, 32'd3);
    wr(6'h0C, 32'h1);
    repeat (9) @(negedge clk);
    rd(6'h0C, v);
    check("R5 before second", v, 32'h0);
    @(negedge clk);
    rd(6'h0C, v);
    check("R5 second expiry", v, 32'h1);
    wr(6'h08, 32'h0);
    wr(6'h0C, 32'h1);
    wr(6'h08, 32'h8);
    rd(6'h08, v);
    check("R9 timer bank no mode bit", v, 32'h0);
  endtask

  task automatic t_guard;
    logic [31:0] v;
    wr(6'h20, 32'd2);
    wr(6'h28, 32'hD);
    repeat (2) @(negedge clk);
    check("R9 no early pulse", {31'b0, wdt_rst_req}, 32'h0);
    @(negedge clk);
    check("R9 pulse", {31'b0, wdt_rst_req}, 32'h1);
    check("R8 guard irq masked", {31'b0, wdt_irq}, 32'h0);
    rd(6'h30, v);
    check("R9 reset flag", v, 32'h1);
    rd(6'h2C, v);
    check("R4 guard status", v, 32'h1);
    @(negedge clk);
    check("R9 pulse one cycle", {31'b0, wdt_rst_req}, 32'h0);
    wr(6'h30, 32'h1);
    rd(6'h30, v);
    check("R9 flag cleared", v, 32'h0);
  endtask

  task automatic t_unlock;
    logic [31:0] v;
    wr(6'h28, 32'h5);
    rd(6'h28, v);
    check("R10 ctrl cannot clear mode", v, 32'hD);
    wr(6'h34, KA);
    wr(6'h34, 32'h0);
    wr(6'h34, KB);
    rd(6'h28, v);
    check("R10 broken sequence", v, 32'hD);
    wr(6'h34, KB);
    rd(6'h28, v);
    check("R10 second word alone", v, 32'hD);
    wr(6'h34, KA);
    wr(6'h34, KB);
    rd(6'h28, v);
    check("R10 unlocked", v, 32'h5);
    rd(6'h34, v);
    check("R10 disable reads 0", v, 32'h0);
    check("R8 guard irq after unlock", {31'b0, wdt_irq}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_hold();
    t_oneshot();
    t_periodic();
    t_guard();
    t_unlock();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule